// File: doc/BRIEF.md
# Iterative Byte Multiply and Word-by-Byte Divide Unit

This unit does the two wide arithmetic operations of a small 8-bit processor core. Multiply forms the full unsigned product of the Y and A registers and returns it split across Y (high byte) and A (low byte). Divide takes Y and A together as a 16-bit dividend, divides it by X, and returns an 8-bit quotient in A and the remainder in Y. The unit also returns an updated status word. A sequencer starts an operation with a one-cycle `start_i` and takes the results when `done_o` pulses. Instruction fetch and register write-back stay with the surrounding core.

When the true quotient does not fit the result width, the divide does not saturate. It switches to a second closed-form formula that gives deterministic, non-standard A and Y values. A divisor of zero goes down that same path, so no operand value is special or undefined. The overflow and half-carry flags come from plain comparisons of the original Y and X. They are not derived from the quotient.

Both operations are bit-serial. Multiply retires one multiplier bit per cycle. Divide runs one adjustment cycle, then produces one quotient bit per cycle, then spends one cycle on the final fix-up.

Top module: `muldiv_unit`

## Requirements
- R1: With `op_i` = 0 (multiply), the result is the unsigned product of Y and A. `y_o` holds its high byte and `a_o` holds its low byte.
- R2: After a multiply, status bit 7 (negative) equals product bit 15 and status bit 1 (zero) is set exactly when the whole 16-bit product is zero. Bits 6 and 3 keep their input values.
- R3: With `op_i` = 1 (divide) and Y < 2·X, `a_o` is the low byte of the quotient of {Y,A} by X and `y_o` is the remainder {Y,A} mod X.
- R4: With `op_i` = 1 and Y ≥ 2·X, let T = {Y,A} − 512·X and D = 256 − X. Then `a_o` = 255 − T/D and `y_o` = X + (T mod D). X = 0 takes this path, which gives `a_o` = 255 − Y and `y_o` = A.
- R5: After a divide, status bit 6 is set exactly when Y ≥ X and bit 3 exactly when Y[3:0] ≥ X[3:0]. Bit 7 copies `a_o` bit 7 and bit 1 is set exactly when `a_o` is zero.
- R6: Status bits 0, 2, 4 and 5 pass from `psw_i` to `psw_o` unchanged by either operation.
- R7: `done_o` is a single-cycle pulse. It is high after the 8th rising edge following the edge that accepts a multiply start, and after the 11th for a divide. Results appear on the same edge.
- R8: A `start_i` that arrives while an operation is in flight is ignored. It does not alter the running operation's results or latency, and it produces no extra `done_o`.
- R9: Reset clears `y_o`, `a_o`, `psw_o` and `done_o` and abandons any operation in flight. Between completions the outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation; sampled only when idle |
| op_i | input | 1 | 0 = multiply, 1 = divide |
| y_i | input | W | Y operand (high dividend byte) |
| a_i | input | W | A operand (low dividend byte) |
| x_i | input | W | X operand (divisor) |
| psw_i | input | 8 | Status word before the operation |
| y_o | output | W | New Y |
| a_o | output | W | New A |
| psw_o | output | 8 | Updated status word |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with the default width of 8. At that width every divisor from 0 to 255 can be swept exhaustively against several dividends. This reaches both sides of the Y = 2·X split, the zero divisor, and quotients that need the ninth bit before truncation. Multiply is driven with zero, all-ones and single-bit patterns. Two status inputs are used, one all-ones and one all-zeros, to expose any flag leakage. Directed cases cover a start issued mid-operation and a reset issued mid-operation.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } md_op_e;

  localparam int PSW_W = 8;
  localparam int PSW_N = 7;
  localparam int PSW_V = 6;
  localparam int PSW_H = 3;
  localparam int PSW_Z = 1;
endpackage

// File: rtl/md_mul_core.sv
module md_mul_core #(
  parameter int W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   mcand_i,
  output logic [2*W-1:0] prod_nxt_o
);
  logic [2*W-1:0] p_q;
  logic [W:0]     sum;

  // right-shift add: high half accumulates, low half holds remaining multiplier bits
  always_comb begin
    sum        = {1'b0, p_q[2*W-1:W]} + (p_q[0] ? {1'b0, mcand_i} : '0);
    prod_nxt_o = {sum, p_q[W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     p_q <= '0;
    else if (load_i) p_q <= {{W{1'b0}}, a_i};
    else if (step_i) p_q <= prod_nxt_o;
  end
endmodule

// File: rtl/md_div_core.sv
module md_div_core #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         prep_i,
  input  logic         step_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] x_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o,
  output logic         ovf_o
);
  localparam int DW = 2 * W;

  logic         ovf_d;
  logic [DW-1:0] num_d;
  logic [W:0]   dvs_d;
  logic [W-1:0] rem_q, quo_q;
  logic [W:0]   low_q, dvs_q;
  logic         ovf_q;
  logic [W:0]   trial;
  logic         ge;
  logic [W-1:0] diff;

  // choose normal or wrap divide; both keep the quotient below 2^(W+1)
  always_comb begin
    ovf_d = {1'b0, y_i} >= {x_i, 1'b0};
    if (ovf_d) begin
      num_d = {y_i, a_i} - {x_i[W-2:0], {(W+1){1'b0}}};
      dvs_d = {1'b1, {W{1'b0}}} - {1'b0, x_i};
    end else begin
      num_d = {y_i, a_i};
      dvs_d = {1'b0, x_i};
    end
  end

  always_comb begin
    trial = {rem_q, low_q[W]};
    ge    = trial >= dvs_q;
    diff  = trial[W-1:0] - dvs_q[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      low_q <= '0;
      dvs_q <= '0;
      quo_q <= '0;
      ovf_q <= 1'b0;
    end else if (prep_i) begin
      rem_q <= {1'b0, num_d[DW-1:W+1]};
      low_q <= num_d[W:0];
      dvs_q <= dvs_d;
      quo_q <= '0;
      ovf_q <= ovf_d;
    end else if (step_i) begin
      rem_q <= ge ? diff : trial[W-1:0];
      low_q <= {low_q[W-1:0], 1'b0};
      quo_q <= {quo_q[W-2:0], ge};
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/md_flags.sv
module md_flags
  import muldiv_pkg::*;
#(
  parameter int W = 8
) (
  input  md_op_e           op_i,
  input  logic [PSW_W-1:0] psw_i,
  input  logic [W-1:0]     y_i,
  input  logic [W-1:0]     x_i,
  input  logic [2*W-1:0]   prod_i,
  input  logic [W-1:0]     quo_i,
  output logic [PSW_W-1:0] psw_o
);
  localparam int HW = W / 2;

  always_comb begin
    psw_o = psw_i;
    if (op_i == OP_MUL) begin
      psw_o[PSW_N] = prod_i[2*W-1];
      psw_o[PSW_Z] = (prod_i == '0);
    end else begin
      psw_o[PSW_V] = (y_i >= x_i);
      psw_o[PSW_H] = (y_i[HW-1:0] >= x_i[HW-1:0]);
      psw_o[PSW_N] = quo_i[W-1];
      psw_o[PSW_Z] = (quo_i == '0);
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             op_i,
  input  logic [W-1:0]     y_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     x_i,
  input  logic [PSW_W-1:0] psw_i,
  output logic [W-1:0]     y_o,
  output logic [W-1:0]     a_o,
  output logic [PSW_W-1:0] psw_o,
  output logic             done_o
);
  localparam int MUL_CYC = W;
  localparam int DIV_CYC = W + 3;
  localparam int CW      = $clog2(DIV_CYC + 1);

  logic             busy_q, done_q;
  logic [CW-1:0]    cnt_q;
  md_op_e           op_q;
  logic [W-1:0]     y_q, a_q, x_q;
  logic [PSW_W-1:0] psw_q;

  logic             accept, last, mul_step, div_prep, div_step;
  logic [2*W-1:0]   prod_nxt;
  logic [W-1:0]     quo, rem, a_div, y_div, y_res, a_res;
  logic             ovf;
  logic [PSW_W-1:0] psw_res;

  always_comb begin
    accept   = start_i & ~busy_q;
    last     = busy_q & (cnt_q == ((op_q == OP_DIV) ? CW'(DIV_CYC) : CW'(MUL_CYC)));
    mul_step = busy_q & (op_q == OP_MUL);
    div_prep = busy_q & (op_q == OP_DIV) & (cnt_q == CW'(1));
    div_step = busy_q & (op_q == OP_DIV) & (cnt_q >= CW'(2)) & (cnt_q <= CW'(W + 2));
  end

  md_mul_core #(.W(W)) u_mul (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .step_i     (mul_step),
    .a_i        (a_i),
    .mcand_i    (y_q),
    .prod_nxt_o (prod_nxt)
  );

  md_div_core #(.W(W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .prep_i (div_prep),
    .step_i (div_step),
    .y_i    (y_q),
    .a_i    (a_q),
    .x_i    (x_q),
    .quo_o  (quo),
    .rem_o  (rem),
    .ovf_o  (ovf)
  );

  // wrap path: quotient is counted down from all-ones, remainder offset by X
  always_comb begin
    a_div = ovf ? ~quo : quo;
    y_div = ovf ? (x_q + rem) : rem;
    if (op_q == OP_MUL) begin
      y_res = prod_nxt[2*W-1:W];
      a_res = prod_nxt[W-1:0];
    end else begin
      y_res = y_div;
      a_res = a_div;
    end
  end

  md_flags #(.W(W)) u_flags (
    .op_i   (op_q),
    .psw_i  (psw_q),
    .y_i    (y_q),
    .x_i    (x_q),
    .prod_i (prod_nxt),
    .quo_i  (a_div),
    .psw_o  (psw_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_MUL;
      y_q    <= '0;
      a_q    <= '0;
      x_q    <= '0;
      psw_q  <= '0;
      y_o    <= '0;
      a_o    <= '0;
      psw_o  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(1);
        op_q   <= md_op_e'(op_i);
        y_q    <= y_i;
        a_q    <= a_i;
        x_q    <= x_i;
        psw_q  <= psw_i;
      end else if (busy_q) begin
        cnt_q <= cnt_q + CW'(1);
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          y_o    <= y_res;
          a_o    <= a_res;
          psw_o  <= psw_res;
        end
      end
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/md_checker.sv
module md_checker #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         op_i,
  input logic [W-1:0] y_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] x_i,
  input logic [7:0]   psw_i,
  input logic [W-1:0] y_o,
  input logic [W-1:0] a_o,
  input logic [7:0]   psw_o,
  input logic         done_o
);
  logic         c_busy, c_op;
  int           c_cnt;
  logic [W-1:0] c_y, c_a, c_x;
  logic [7:0]   c_psw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_busy <= 1'b0;
      c_op   <= 1'b0;
      c_cnt  <= 0;
      c_y    <= '0;
      c_a    <= '0;
      c_x    <= '0;
      c_psw  <= '0;
    end else if (start_i && (!c_busy || done_o)) begin
      c_busy <= 1'b1;
      c_cnt  <= 0;
      c_op   <= op_i;
      c_y    <= y_i;
      c_a    <= a_i;
      c_x    <= x_i;
      c_psw  <= psw_i;
    end else begin
      if (done_o) c_busy <= 1'b0;
      c_cnt <= c_cnt + 1;
    end
  end

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (c_busy && c_cnt == (c_op ? W + 3 : W)));

  a_r1_mul_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !c_op) |-> ({y_o, a_o} == c_y * c_a));

  a_r5_div_v_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && c_op) |-> (psw_o[6] == (c_y >= c_x)));

  a_r6_keep_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (psw_o[0] == c_psw[0] && psw_o[2] == c_psw[2] &&
                psw_o[4] == c_psw[4] && psw_o[5] == c_psw[5]));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(y_o) && $stable(a_o) && $stable(psw_o)));
endmodule

bind muldiv_unit md_checker #(.W(W)) u_md_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .op_i    (op_i),
  .y_i     (y_i),
  .a_i     (a_i),
  .x_i     (x_i),
  .psw_i   (psw_i),
  .y_o     (y_o),
  .a_o     (a_o),
  .psw_o   (psw_o),
  .done_o  (done_o)
);

// File: tb/tb_muldiv_unit.sv
module tb_muldiv_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       op = 1'b0;
  logic [7:0] y_in = '0, a_in = '0, x_in = '0, psw_in = '0;
  logic [7:0] y_out, a_out, psw_out;
  logic       done;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  muldiv_unit #(.W(8)) dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start),
    .op_i    (op),
    .y_i     (y_in),
    .a_i     (a_in),
    .x_i     (x_in),
    .psw_i   (psw_in),
    .y_o     (y_out),
    .a_o     (a_out),
    .psw_o   (psw_out),
    .done_o  (done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // independent model of the requirements
  task automatic model(input bit o, input int y, input int a, input int x, input int p,
                       output int ey, output int ea, output int ep);
    int ya, prod, t, d;
    ya = y * 256 + a;
    ep = p;
    if (!o) begin
      prod = y * a;
      ey = prod / 256;
      ea = prod % 256;
      ep = (ep & ~8'h82) | ((prod >= 32768) ? 8'h80 : 0) | ((prod == 0) ? 8'h02 : 0);
    end else begin
      if (y < 2 * x) begin
        ea = (ya / x) % 256;
        ey = ya % x;
      end else begin
        t  = ya - 512 * x;
        d  = 256 - x;
        ea = (255 - t / d) % 256;
        ey = (x + t % d) % 256;
      end
      ep = ep & ~8'hCA;
      if (y >= x) ep |= 8'h40;
      if ((y % 16) >= (x % 16)) ep |= 8'h08;
      if (ea >= 128) ep |= 8'h80;
      if (ea == 0) ep |= 8'h02;
    end
  endtask

  // issue one operation; optional second start at cycle intr_at while busy
  task automatic run_op(input string req, input bit o, input int y, input int a, input int x,
                        input int p, input int intr_at);
    int lat, ey, ea, ep;
    model(o, y, a, x, p, ey, ea, ep);
    @(negedge clk);
    op = o; y_in = 8'(y); a_in = 8'(a); x_in = 8'(x); psw_in = 8'(p); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
      if (lat == intr_at) begin
        op = ~o; y_in = 8'h5A; a_in = 8'hC3; x_in = 8'h07; psw_in = ~8'(p); start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    chk({req, " R7 latency"}, lat, o ? 11 : 8);
    chk({req, " y"}, int'(y_out), ey);
    chk({req, " a"}, int'(a_out), ea);
    chk({req, " psw"}, int'(psw_out), ep);
    @(negedge clk);
    chk("R7 single-cycle done", int'(done), 0);
  endtask

  task automatic t_reset();
    chk("R9 reset done", int'(done), 0);
    chk("R9 reset y", int'(y_out), 0);
    chk("R9 reset a", int'(a_out), 0);
    chk("R9 reset psw", int'(psw_out), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle after reset", int'(done), 0);
  endtask

  task automatic t_mul();
    run_op("R1 mul 0x0", 0, 0, 0, 0, 8'h00, -1);
    run_op("R1 mul ff*ff", 0, 255, 255, 0, 8'hFF, -1);
    run_op("R1 mul 80*2", 0, 8'h80, 2, 0, 8'h00, -1);
    run_op("R2 mul sign bit", 0, 8'hC0, 8'h03, 0, 8'h48, -1);
    run_op("R2 mul zero side", 0, 0, 8'h77, 0, 8'hFF, -1);
    run_op("R6 mul passthru", 0, 8'h13, 8'h0B, 8'h99, 8'h35, -1);
  endtask

  task automatic t_div_sweep();
    int yas[6] = '{16'h0000, 16'h1234, 16'h7FFF, 16'hFFFF, 16'h80FF, 16'h0101};
    for (int i = 0; i < 6; i++) begin
      for (int x = 0; x < 256; x++) begin
        run_op((yas[i] / 256 < 2 * x) ? "R3 div normal" : "R4 div wrap", 1,
               yas[i] / 256, yas[i] % 256, x, (i % 2) ? 8'hFF : 8'h00, -1);
      end
    end
  endtask

  task automatic t_div_corners();
    run_op("R4 div by zero", 1, 8'h12, 8'h34, 0, 8'h00, -1);
    chk("R4 zero-div a=255-Y", int'(a_out), 8'hED);
    chk("R4 zero-div y=A", int'(y_out), 8'h34);
    run_op("R3 div 9-bit quotient", 1, 8'h01, 8'hFF, 1, 8'h00, -1);
    run_op("R5 div flags nibble", 1, 8'h2F, 8'h00, 8'h3E, 8'hFF, -1);
    run_op("R6 div passthru", 1, 8'h40, 8'h10, 8'h21, 8'h35, -1);
  endtask

  task automatic t_busy();
    int seen;
    run_op("R8 mul with late start", 0, 3, 5, 0, 8'h00, 3);
    run_op("R8 div with late start", 1, 8'h10, 8'h00, 8'h30, 8'h00, 6);
    seen = 0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (done) seen++;
    end
    chk("R8 no extra done", seen, 0);
  endtask

  task automatic t_hold_and_abort();
    int hy, ha, hp, seen;
    hy = int'(y_out); ha = int'(a_out); hp = int'(psw_out);
    repeat (5) @(negedge clk);
    chk("R9 hold y", int'(y_out), hy);
    chk("R9 hold a", int'(a_out), ha);
    chk("R9 hold psw", int'(psw_out), hp);
    op = 1'b1; y_in = 8'h20; a_in = 8'h00; x_in = 8'h40; psw_in = 8'hFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    seen = 0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (done) seen++;
    end
    chk("R9 abort no done", seen, 0);
    chk("R9 abort y", int'(y_out), 0);
    chk("R9 abort psw", int'(psw_out), 0);
  endtask

  initial begin
    t_reset();
    t_mul();
    t_div_corners();
    t_busy();
    t_div_sweep();
    t_hold_and_abort();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule